// File: doc/BRIEF.md
# Two-Way Set-Associative Read Cache

This block is a read-only cache that sits between a byte-reading requester and a slower backing memory. A byte address is split into three fields. The low bits give the byte offset inside a block, the middle bits pick a set, and the upper bits form the tag. Each set holds two ways. The tags of both ways are compared against the address tag at the same time. When a valid way matches, the addressed byte is returned from that way's stored block.

On a miss the requester is stalled. The block is fetched from backing memory as one whole line and written into a victim way. The victim is an empty way if the set has one, with way 0 taken first. When both ways are full, the victim is the way touched least recently. Each set keeps one recency bit that names the way not most recently used. Every hit and every fill moves that bit to the other way.

A control state machine with three states sequences each access:
- `ST_IDLE`: the block is ready. A request moves it to `ST_LOOKUP` (transition *accept*).
- `ST_LOOKUP`: the tags are compared. A hit answers and returns to `ST_IDLE` (transition *hit-return*). A miss records the victim and moves to `ST_REFILL` (transition *miss-fetch*).
- `ST_REFILL`: the block holds its memory request until the line arrives. It then writes the line and goes back to `ST_LOOKUP` (transition *fill-retry*), where the retried lookup now hits.

Top module: `assoc2_read_cache`

## Requirements
- R1: After reset every line is invalid, so the first access to any address misses. While idle, `req_ready` is 1 and both `resp_valid` and `mem_req` are 0.
- R2: A request accepted while `req_ready` is 1 that hits gives `resp_valid` = 1 in the next cycle. In that cycle `resp_refilled` is 0 and `resp_data` is the stored byte at offset `addr[OFF_W-1:0]`.
- R3: On a miss, `mem_req` rises two cycles after the request is accepted. `mem_addr` equals `addr >> OFF_W`. Both stay steady, with `req_ready` at 0, until a cycle with `mem_valid` = 1.
- R4: In the cycle after `mem_valid` is sampled high, the response appears with `resp_valid` = 1 and `resp_refilled` = 1. The data is byte `off` of `mem_line`, which is bits `[8*off+7 : 8*off]` for a byte width of 8.
- R5: A fill goes into an invalid way of the set if one exists, and into way 0 when both ways are invalid.
- R6: When both ways of the set are valid, a fill replaces the least recently used way.
- R7: Every hit and every fill marks the touched way as most recently used.
- R8: Two blocks with the same set index but different tags both stay resident once each has missed, so accessing them alternately then hits every time.
- R9: No set ever has a valid tag match in both ways at once.
- R10: A request presented while `req_ready` is 0 is ignored. It gets no response, changes no stored state, and does not alter `mem_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request strobe |
| req_addr | input | ADDR_W | Byte address of the request |
| req_ready | output | 1 | High when a request can be accepted |
| resp_valid | output | 1 | Response byte is valid this cycle |
| resp_data | output | DATA_W | Returned byte |
| resp_refilled | output | 1 | Response followed a refill from memory |
| mem_req | output | 1 | Backing memory line request |
| mem_addr | output | ADDR_W-OFF_W | Block address of the requested line |
| mem_valid | input | 1 | Requested line is present on mem_line |
| mem_line | input | DATA_W*2^OFF_W | Whole block, byte i in bits [DATA_W*i +: DATA_W] |

## Verification
The hardest case to reach from the ports is a replacement in which the recency bit, and not an empty way, picks the victim. The stimulus reaches it by filling both ways of one set with two tags and then touching one of them again. A third tag for the same set then follows. Afterwards, re-accessing each displaced and kept block shows which way was chosen, as a miss or a hit against a behavioural model of valid, tag and recency state. A second hard case is a request raised during a refill stall. It is driven in the middle of a memory wait, and a later access to that same address must still miss.

// File: rtl/cache_pkg.sv
package cache_pkg;
    localparam int NUM_WAYS = 2;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOOKUP = 2'd1,
        ST_REFILL = 2'd2
    } ctrl_state_e;

    // Victim choice: first invalid way (way 0 preferred), else recency bit.
    function automatic logic pick_victim(input logic [NUM_WAYS-1:0] vld,
                                         input logic lru_bit);
        if (!vld[0])      return 1'b0;
        else if (!vld[1]) return 1'b1;
        else              return lru_bit;
    endfunction
endpackage

// File: rtl/tag_store.sv
module tag_store
    import cache_pkg::*;
#(
    parameter int SET_W = 2,
    parameter int TAG_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [SET_W-1:0]     rd_set,
    input  logic [TAG_W-1:0]     rd_tag,
    input  logic                 wr_en,
    input  logic [SET_W-1:0]     wr_set,
    input  logic                 wr_way,
    input  logic [TAG_W-1:0]     wr_tag,
    output logic [NUM_WAYS-1:0]  match_way,
    output logic [NUM_WAYS-1:0]  valid_way
);
    localparam int NUM_SETS = 1 << SET_W;

    logic [NUM_WAYS-1:0] valid_q [NUM_SETS];
    logic [TAG_W-1:0]    tag_q   [NUM_SETS][NUM_WAYS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < NUM_SETS; s++) valid_q[s] <= '0;
        end else if (wr_en) begin
            valid_q[wr_set][wr_way] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) tag_q[wr_set][wr_way] <= wr_tag;
    end

    assign valid_way = valid_q[rd_set];

    // Parallel compare, one comparator per way
    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_cmp
        assign match_way[w] = valid_q[rd_set][w] && (tag_q[rd_set][w] == rd_tag);
    end

    // R9: never two matching ways in one set
    p_single_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(match_way) <= 1);
endmodule

// File: rtl/data_store.sv
module data_store
    import cache_pkg::*;
#(
    parameter int SET_W  = 2,
    parameter int OFF_W  = 2,
    parameter int DATA_W = 8
) (
    input  logic                          clk,
    input  logic [SET_W-1:0]              rd_set,
    input  logic [OFF_W-1:0]              rd_off,
    input  logic                          rd_way,
    input  logic                          wr_en,
    input  logic [SET_W-1:0]              wr_set,
    input  logic                          wr_way,
    input  logic [(DATA_W<<OFF_W)-1:0]    wr_line,
    output logic [DATA_W-1:0]             rd_byte
);
    localparam int NUM_SETS = 1 << SET_W;
    localparam int BYTES    = 1 << OFF_W;
    localparam int LINE_W   = DATA_W * BYTES;

    logic [LINE_W-1:0] way_line [NUM_WAYS];
    logic [LINE_W-1:0] sel_line;

    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
        logic [LINE_W-1:0] line_q [NUM_SETS];
        always_ff @(posedge clk) begin
            if (wr_en && (wr_way == 1'(w))) line_q[wr_set] <= wr_line;
        end
        assign way_line[w] = line_q[rd_set];
    end

    assign sel_line = way_line[rd_way];

    // Offset multiplexer
    always_comb begin
        rd_byte = '0;
        for (int b = 0; b < BYTES; b++) begin
            if (rd_off == OFF_W'(b)) rd_byte = sel_line[b*DATA_W +: DATA_W];
        end
    end
endmodule

// File: rtl/lru_store.sv
module lru_store #(
    parameter int SET_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SET_W-1:0] rd_set,
    input  logic             touch_en,
    input  logic [SET_W-1:0] touch_set,
    input  logic             touch_way,
    output logic             lru_bit
);
    localparam int NUM_SETS = 1 << SET_W;

    logic [NUM_SETS-1:0] older_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        older_q <= '0;
        else if (touch_en) older_q[touch_set] <= ~touch_way;
    end

    assign lru_bit = older_q[rd_set];

    // R7: touched way is no longer the least recent one
    p_touch_marks_recent_r7: assert property (@(posedge clk) disable iff (!rst_n)
        touch_en |=> (older_q[$past(touch_set)] != $past(touch_way)));
endmodule

// File: rtl/cache_ctrl.sv
module cache_ctrl
    import cache_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [NUM_WAYS-1:0] match_way,
    input  logic [NUM_WAYS-1:0] valid_way,
    input  logic                lru_bit,
    input  logic                mem_valid,
    output logic                ready,
    output logic                capture,
    output logic                resp_valid,
    output logic                resp_refilled,
    output logic                mem_req,
    output logic                fill_en,
    output logic                fill_way,
    output logic                touch_en,
    output logic                touch_way,
    output logic                hit_way
);
    ctrl_state_e state_q, state_d;
    logic        victim_q;
    logic        refilled_q;
    logic        hit;

    assign hit     = |match_way;
    assign hit_way = match_way[1];

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid) state_d = ST_LOOKUP;
            ST_LOOKUP: state_d = hit ? ST_IDLE : ST_REFILL;
            ST_REFILL: if (mem_valid) state_d = ST_LOOKUP;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Victim and refill marker
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            victim_q   <= 1'b0;
            refilled_q <= 1'b0;
        end else begin
            if (state_q == ST_LOOKUP && !hit)
                victim_q <= pick_victim(valid_way, lru_bit);
            if (state_q == ST_REFILL && mem_valid)
                refilled_q <= 1'b1;
            else if (state_q == ST_IDLE)
                refilled_q <= 1'b0;
        end
    end

    // Outputs
    always_comb begin
        ready         = 1'b0;
        capture       = 1'b0;
        resp_valid    = 1'b0;
        resp_refilled = 1'b0;
        mem_req       = 1'b0;
        fill_en       = 1'b0;
        fill_way      = victim_q;
        touch_en      = 1'b0;
        touch_way     = hit_way;
        unique case (state_q)
            ST_IDLE: begin
                ready   = 1'b1;
                capture = req_valid;
            end
            ST_LOOKUP: begin
                resp_valid    = hit;
                resp_refilled = hit && refilled_q;
                touch_en      = hit;
            end
            ST_REFILL: begin
                mem_req   = 1'b1;
                fill_en   = mem_valid;
                touch_en  = mem_valid;
                touch_way = victim_q;
            end
            default: ;
        endcase
    end

    // R1: idle means no response and no memory request
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (!mem_req && !resp_valid));
    // R3: request held until the line arrives
    p_hold_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_valid) |=> (mem_req && !ready));
    // R4: fill is followed by a refilled hit
    p_fill_then_resp_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> (resp_valid && resp_refilled));
    // R5: an empty way 0 is chosen ahead of anything else
    p_invalid_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOOKUP && !hit && !valid_way[0]) |=> (victim_q == 1'b0));
endmodule

// File: rtl/assoc2_read_cache.sv
module assoc2_read_cache
    import cache_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int OFF_W  = 2,
    parameter int SET_W  = 2,
    parameter int DATA_W = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid,
    input  logic [ADDR_W-1:0]             req_addr,
    output logic                          req_ready,
    output logic                          resp_valid,
    output logic [DATA_W-1:0]             resp_data,
    output logic                          resp_refilled,
    output logic                          mem_req,
    output logic [ADDR_W-OFF_W-1:0]       mem_addr,
    input  logic                          mem_valid,
    input  logic [(DATA_W<<OFF_W)-1:0]    mem_line
);
    localparam int TAG_W = ADDR_W - OFF_W - SET_W;

    logic [ADDR_W-1:0]   addr_q;
    logic [OFF_W-1:0]    a_off;
    logic [SET_W-1:0]    a_set;
    logic [TAG_W-1:0]    a_tag;
    logic                capture;
    logic [NUM_WAYS-1:0] match_way, valid_way;
    logic                lru_bit, fill_en, fill_way, touch_en, touch_way, hit_way;
    logic [DATA_W-1:0]   rd_byte;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       addr_q <= '0;
        else if (capture) addr_q <= req_addr;
    end

    assign a_off    = addr_q[OFF_W-1:0];
    assign a_set    = addr_q[OFF_W +: SET_W];
    assign a_tag    = addr_q[ADDR_W-1 -: TAG_W];
    assign mem_addr = addr_q[ADDR_W-1:OFF_W];

    tag_store #(.SET_W(SET_W), .TAG_W(TAG_W)) u_tags (
        .clk(clk), .rst_n(rst_n), .rd_set(a_set), .rd_tag(a_tag),
        .wr_en(fill_en), .wr_set(a_set), .wr_way(fill_way), .wr_tag(a_tag),
        .match_way(match_way), .valid_way(valid_way)
    );

    data_store #(.SET_W(SET_W), .OFF_W(OFF_W), .DATA_W(DATA_W)) u_data (
        .clk(clk), .rd_set(a_set), .rd_off(a_off), .rd_way(hit_way),
        .wr_en(fill_en), .wr_set(a_set), .wr_way(fill_way), .wr_line(mem_line),
        .rd_byte(rd_byte)
    );

    lru_store #(.SET_W(SET_W)) u_lru (
        .clk(clk), .rst_n(rst_n), .rd_set(a_set), .touch_en(touch_en),
        .touch_set(a_set), .touch_way(touch_way), .lru_bit(lru_bit)
    );

    cache_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .match_way(match_way), .valid_way(valid_way), .lru_bit(lru_bit),
        .mem_valid(mem_valid), .ready(req_ready), .capture(capture),
        .resp_valid(resp_valid), .resp_refilled(resp_refilled),
        .mem_req(mem_req), .fill_en(fill_en), .fill_way(fill_way),
        .touch_en(touch_en), .touch_way(touch_way), .hit_way(hit_way)
    );

    assign resp_data = resp_valid ? rd_byte : '0;

    // R10: block address held steady while a line is outstanding
    p_addr_steady_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_valid) |=> $stable(mem_addr));
endmodule

// File: tb/assoc2_read_cache_test.sv
module assoc2_read_cache_test;
    localparam int ADDR_W = 8, OFF_W = 2, SET_W = 2, DATA_W = 8;
    localparam int LINE_W = DATA_W << OFF_W;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic req_ready, resp_valid, resp_refilled, mem_req;
    logic [DATA_W-1:0] resp_data;
    logic [ADDR_W-OFF_W-1:0] mem_addr;
    logic mem_valid = 1'b0;
    logic [LINE_W-1:0] mem_line = '0;

    int checks = 0, errors = 0;

    // Behavioural model state
    bit mv [4][2];
    int mt [4][2];
    bit ml [4];

    always #10 clk = ~clk;

    assoc2_read_cache #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .SET_W(SET_W), .DATA_W(DATA_W)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_ready(req_ready), .resp_valid(resp_valid), .resp_data(resp_data),
        .resp_refilled(resp_refilled), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_valid(mem_valid), .mem_line(mem_line)
    );

    function automatic int mem_byte(int a);
        return (a * 37 + 11) & 255;
    endfunction

    task automatic check(bit ok, string rq, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    task automatic access(int a, int lat, bit poke, string rq);
        int s, tg, hw, vic;
        s = (a >> 2) & 3; tg = a >> 4; hw = -1;
        for (int w = 0; w < 2; w++) if (mv[s][w] && mt[s][w] == tg) hw = w;
        @(negedge clk); req_valid = 1'b1; req_addr = ADDR_W'(a);
        @(negedge clk); req_valid = 1'b0;
        check(resp_valid == (hw >= 0), rq, "hit/miss", int'(resp_valid), int'(hw >= 0));
        if (hw >= 0) begin
            check(resp_refilled == 1'b0, "R2", "refilled on hit", int'(resp_refilled), 0);
            check(int'(resp_data) == mem_byte(a), "R2", "hit data", int'(resp_data), mem_byte(a));
            ml[s] = (hw == 0);
        end else begin
            vic = !mv[s][0] ? 0 : (!mv[s][1] ? 1 : int'(ml[s]));
            @(negedge clk);
            check(mem_req && !req_ready, "R3", "mem_req/stall", int'(mem_req), 1);
            check(int'(mem_addr) == (a >> 2), "R3", "mem_addr", int'(mem_addr), a >> 2);
            for (int i = 0; i < lat; i++) begin
                if (poke && i == 0) begin req_valid = 1'b1; req_addr = ADDR_W'(a ^ 8'h80); end
                @(negedge clk); req_valid = 1'b0;
                check(mem_req && int'(mem_addr) == (a >> 2), "R10", "held request", int'(mem_addr), a >> 2);
            end
            mem_valid = 1'b1;
            for (int b = 0; b < 4; b++) mem_line[b*8 +: 8] = 8'(mem_byte((a & ~3) + b));
            @(negedge clk); mem_valid = 1'b0;
            check(resp_valid && resp_refilled, "R4", "refilled response", int'(resp_refilled), 1);
            check(int'(resp_data) == mem_byte(a), "R4", "fill data", int'(resp_data), mem_byte(a));
            mv[s][vic] = 1'b1; mt[s][vic] = tg; ml[s] = (vic == 0);
        end
        @(negedge clk);
        check(req_ready && !resp_valid && !mem_req, "R10", "back to idle", int'(req_ready), 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual 0 expected 1");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(req_ready && !resp_valid && !mem_req, "R1", "reset outputs", int'(req_ready), 1);
        rst_n = 1'b1;
        access(8'h02, 0, 0, "R1");   // cold miss, way 0
        access(8'h03, 0, 0, "R2");   // hit, other offset
        access(8'h12, 2, 1, "R5");   // same set, fills empty way 1; request poked during stall
        access(8'h02, 0, 0, "R8");
        access(8'h12, 0, 0, "R8");
        access(8'h02, 0, 0, "R8");   // way 0 most recent
        access(8'h22, 1, 0, "R6");   // replaces 0x12
        access(8'h02, 0, 0, "R7");   // hit keeps way 0 recent
        access(8'h12, 0, 0, "R6");   // replaces 0x22
        access(8'h22, 0, 0, "R6");   // replaces 0x02
        access(8'h92, 0, 0, "R10");  // poked address must not be resident
        for (int i = 0; i < 200; i++)
            access((i * 53 + 7) & 8'h3f | ((i & 1) << 7), i % 3, (i % 7) == 0, "R9");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule